// File: doc/BRIEF.md
# Strobe-Gated Read Capture Path

This block is the receive side of a source-synchronous parallel PHY, modelled in one synthesizable clock domain. The core raises a read-enable pulse when it issues a read to the external device. The block sends that pulse down two delay lines, and each line has its own latency setting. One delayed copy becomes the strobe enable. Strobe pulses count only while it is high, so edges that do not belong to the returning burst are ignored. The other delayed copy becomes the enable that lets finished words into the read FIFO.

Each gated strobe cycle supplies a rising-edge sample and a falling-edge sample. In SDR mode it supplies only the rising-edge sample. These samples are packed into words of 2, 4 or 8 samples. A finished word goes into the FIFO at the clock edge where its last sample is taken, with no extra register stage. The core drains the FIFO with a pop input. The FIFO reports a write that finds it full as an overflow, and a pop that finds it empty as an underflow. Neither case changes the stored data.

Top module: `rd_capture_path`

## Requirements
- R1: If `rd_en` is high in cycle c, `sten_o` is high in exactly cycle c+L+1, where L = `lat_sten` (0..31), provided `lat_sten` does not change during that window.
- R2: The FIFO-enable line behaves in the same way with L = `lat_fifo`. Its timing does not depend on `lat_sten`, and changing `lat_sten` does not disturb it.
- R3: In any cycle where a latency input differs from its value in the previous cycle, that line's output is low. Every pulse still in flight on that line is discarded, including a `rd_en` presented in that same cycle.
- R4: A `strb_pulse` seen while `sten_o` is low captures nothing: `word_vld` stays low and the FIFO is unchanged.
- R5: In DDR mode (`sdr_mode`=0), each gated cycle adds two samples, `dq_pos` first and then `dq_neg`. `fac_sel` sets the samples per word: 0→2, 1→4, 2 or 3→8. Sample i of a word occupies bits [4i+3:4i], and lanes at or above the factor are zero.
- R6: In SDR mode (`sdr_mode`=1), each gated cycle adds only `dq_pos`, and `dq_neg` is discarded, so a word needs as many gated cycles as its factor.
- R7: `word_vld` is high in exactly the cycle in which a word's last sample is presented. When `rfifo_en_o` is also high, the word can be read at `rd_data` in the next cycle.
- R8: When `sten_o` goes low, a partly assembled word is discarded. The next word starts from lane 0.
- R9: A word completed while `rfifo_en_o` is low is not written to the FIFO.
- R10: The FIFO (depth 4) returns words in write order. `rd_data` shows the oldest word whenever `rd_empty` is low, and a `pop` removes that word at the next edge.
- R11: A write that arrives while the FIFO is full is dropped. `ovf_flag` is high for one cycle in the cycle that follows, and the stored words stay intact.
- R12: A `pop` while the FIFO is empty changes nothing. `udf_flag` is high for one cycle in the cycle that follows.
- R13: After reset, `sten_o`, `rfifo_en_o`, `word_vld`, `rd_full`, `ovf_flag` and `udf_flag` are low, and `rd_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read-enable pulse from the core |
| lat_sten | input | 5 | Latency of the strobe-enable line |
| lat_fifo | input | 5 | Latency of the FIFO-enable line |
| sdr_mode | input | 1 | 1 = keep rising-edge samples only |
| fac_sel | input | 2 | Samples per word: 0→2, 1→4, 2/3→8 |
| strb_pulse | input | 1 | Strobe activity in this cycle |
| dq_pos | input | 4 | Sample taken on the rising strobe edge |
| dq_neg | input | 4 | Sample taken on the falling strobe edge |
| pop | input | 1 | Core removes the oldest FIFO word |
| sten_o | output | 1 | Delayed strobe enable |
| rfifo_en_o | output | 1 | Delayed FIFO write enable |
| word_vld | output | 1 | A word completes in this cycle |
| rd_data | output | 32 | Oldest FIFO word (show-ahead) |
| rd_empty | output | 1 | FIFO holds no word |
| rd_full | output | 1 | FIFO holds four words |
| ovf_flag | output | 1 | Previous cycle's write was dropped on a full FIFO |
| udf_flag | output | 1 | Previous cycle popped an empty FIFO |

## Verification
The latency assertions assume that the latency inputs stay unchanged while a pulse is in flight, except when a flush is the intended effect. The stimulus therefore changes a latency setting only between runs, or deliberately in the flush scenario. The FIFO assertions assume that `fac_sel` and `sdr_mode` stay fixed while a word is being assembled. The bench changes them only while `sten_o` is low. The latency sweeps cover every one of the 32 settings on both lines, with the two lines at mirrored values. The packing checks cover every factor code in both sample modes.

// File: rtl/rdc_pkg.sv
// Shared definitions for the read capture path.
// Assumes the deserializer's maximum factor is 8.
package rdc_pkg;

    typedef enum logic [1:0] {
        DS_BY2  = 2'd0,
        DS_BY4  = 2'd1,
        DS_BY8  = 2'd2,
        DS_BY8X = 2'd3
    } ds_sel_e;

    // Samples per word for a factor code
    function automatic int unsigned ds_samples(input logic [1:0] sel);
        case (ds_sel_e'(sel))
            DS_BY2:  return 2;
            DS_BY4:  return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/rdc_lat_line.sv
// Programmable enable delay line.
// Output is the input delayed by lat+1 cycles. A change of lat clears
// every pulse in flight and blocks the output in the cycle of the change.
// Assumes DEPTH == 2**LAT_W.
module rdc_lat_line #(
    parameter int DEPTH = 32,
    localparam int LAT_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic [LAT_W-1:0] lat,
    output logic             en_out
);

    logic [DEPTH-1:0] pipe_q;
    logic [LAT_W-1:0] lat_q;
    logic             lat_chg;

    // Detect a new latency setting
    assign lat_chg = (lat != lat_q);

    // Shift the enable history, flushing on a latency change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            lat_q  <= lat;
        end else begin
            lat_q <= lat;
            if (lat_chg) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[DEPTH-2:0], en_in};
            end
        end
    end

    // Tap the selected stage, blocked while the setting moves
    assign en_out = pipe_q[lat] & ~lat_chg;

endmodule

// File: rtl/rdc_deser.sv
// Strobe-gated deserializer.
// Packs one (SDR) or two (DDR) samples per gated strobe cycle into a word
// of 2, 4 or 8 samples. The finished word is presented combinationally in
// the cycle of its last sample. A low gate discards a partial word.
// Assumes MAX_FAC is 8 and the mode inputs are steady during a word.
module rdc_deser
    import rdc_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int MAX_FAC = 8,
    localparam int WORD_W = DATA_W * MAX_FAC,
    localparam int CNT_W  = $clog2(MAX_FAC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              strb,
    input  logic              sdr,
    input  logic [1:0]        fac_sel,
    input  logic [DATA_W-1:0] dq_pos,
    input  logic [DATA_W-1:0] dq_neg,
    output logic              done,
    output logic [WORD_W-1:0] word
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  fac_n;
    logic [CNT_W-1:0]  step;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nxt;
    logic              take;

    // Place this cycle's samples into the next word image
    always_comb begin
        take    = strb & gate_en;
        step    = sdr ? CNT_W'(1) : CNT_W'(2);
        fac_n   = CNT_W'(ds_samples(fac_sel));
        cnt_nxt = cnt_q + step;
        acc_nxt = acc_q;
        for (int i = 0; i < MAX_FAC; i++) begin
            if (take && (CNT_W'(i) == cnt_q)) begin
                acc_nxt[i*DATA_W +: DATA_W] = dq_pos;
            end
            if (take && !sdr && (CNT_W'(i) == cnt_q + CNT_W'(1))) begin
                acc_nxt[i*DATA_W +: DATA_W] = dq_neg;
            end
        end
        done = take && (cnt_nxt >= fac_n);
        word = acc_nxt;
    end

    // Keep the partial word, clearing it when done or ungated
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_en || done) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_nxt;
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/rdc_rd_fifo.sv
// Show-ahead read FIFO with overflow and underflow pulses.
// A write while full and a pop while empty are both ignored and flagged one
// cycle later. A write while full is dropped even if a pop happens in the
// same cycle. Assumes DEPTH is a power of two.
module rdc_rd_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic              empty,
    output logic              full,
    output logic              ovf,
    output logic              udf
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [PTR_W:0]    cnt_q;
    logic              do_wr;
    logic              do_rd;

    // Qualify the requests against the occupancy
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (PTR_W+1)'(DEPTH));
    assign do_wr = wr & ~full;
    assign do_rd = pop & ~empty;
    assign rdata = mem[rptr_q];

    // Store the accepted word
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr_q] <= wdata;
        end
    end

    // Advance the pointers and the occupancy, raise the error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            if (do_wr) wptr_q <= wptr_q + PTR_W'(1);
            if (do_rd) rptr_q <= rptr_q + PTR_W'(1);
            cnt_q <= cnt_q + (PTR_W+1)'(do_wr) - (PTR_W+1)'(do_rd);
            ovf   <= wr & full;
            udf   <= pop & empty;
        end
    end

endmodule

// File: rtl/rd_capture_path.sv
// Read capture path top.
// Splits the core read enable into a strobe-enable line and a FIFO-enable
// line, gates the strobe, deserializes the gated samples and writes each
// finished word into the read FIFO at the edge of its last sample.
// Assumes a single clock domain with strobe activity given per cycle.
module rd_capture_path #(
    parameter int DATA_W     = 4,
    parameter int MAX_FAC    = 8,
    parameter int LAT_DEPTH  = 32,
    parameter int FIFO_DEPTH = 4,
    localparam int LAT_W     = $clog2(LAT_DEPTH),
    localparam int WORD_W    = DATA_W * MAX_FAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [LAT_W-1:0]  lat_sten,
    input  logic [LAT_W-1:0]  lat_fifo,
    input  logic              sdr_mode,
    input  logic [1:0]        fac_sel,
    input  logic              strb_pulse,
    input  logic [DATA_W-1:0] dq_pos,
    input  logic [DATA_W-1:0] dq_neg,
    input  logic              pop,
    output logic              sten_o,
    output logic              rfifo_en_o,
    output logic              word_vld,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_full,
    output logic              ovf_flag,
    output logic              udf_flag
);

    logic [WORD_W-1:0] cap_word;

    // Strobe-enable delay
    rdc_lat_line #(.DEPTH(LAT_DEPTH)) i_sten_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (rd_en),
        .lat    (lat_sten),
        .en_out (sten_o)
    );

    // FIFO-enable delay
    rdc_lat_line #(.DEPTH(LAT_DEPTH)) i_fifo_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (rd_en),
        .lat    (lat_fifo),
        .en_out (rfifo_en_o)
    );

    // Gated capture and packing
    rdc_deser #(.DATA_W(DATA_W), .MAX_FAC(MAX_FAC)) i_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (sten_o),
        .strb    (strb_pulse),
        .sdr     (sdr_mode),
        .fac_sel (fac_sel),
        .dq_pos  (dq_pos),
        .dq_neg  (dq_neg),
        .done    (word_vld),
        .word    (cap_word)
    );

    // Read FIFO, written at the edge that completes a word
    rdc_rd_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (word_vld & rfifo_en_o),
        .wdata (cap_word),
        .pop   (pop),
        .rdata (rd_data),
        .empty (rd_empty),
        .full  (rd_full),
        .ovf   (ovf_flag),
        .udf   (udf_flag)
    );

endmodule

// File: rtl/rd_capture_path_chk.sv
// Temporal checks on the read capture path ports.
// Assumes the latency inputs only move between reads or for a flush.
module rd_capture_path_chk #(
    parameter int LAT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [LAT_W-1:0] lat_sten,
    input logic [LAT_W-1:0] lat_fifo,
    input logic             pop,
    input logic             sten_o,
    input logic             rfifo_en_o,
    input logic             word_vld,
    input logic             rd_empty,
    input logic             rd_full,
    input logic             ovf_flag,
    input logic             udf_flag
);

    AST_STEN_LAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lat_sten == '0 && $stable(lat_sten)) |=> (!$stable(lat_sten) || sten_o)); // R1
    AST_FIFO_LAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lat_fifo == '0 && $stable(lat_fifo)) |=> (!$stable(lat_fifo) || rfifo_en_o)); // R2
    AST_STEN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_sten) |-> !sten_o); // R3
    AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_fifo) |-> !rfifo_en_o); // R3
    AST_GATED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> sten_o); // R4
    AST_NO_WRITE_UNQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && !(word_vld && rfifo_en_o)) |=> rd_empty); // R9
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_full && rd_empty)); // R10
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> $past(word_vld && rfifo_en_o && rd_full)); // R11
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_full && !pop) |=> rd_full); // R11
    AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag |-> $past(pop && rd_empty)); // R12

endmodule

bind rd_capture_path rd_capture_path_chk #(.LAT_W(LAT_W)) i_chk (.*);

// File: tb/test_rd_capture_path.sv
// Self-checking bench: sweeps every latency on both lines, every factor code
// in both sample modes, and the flush, gating, drop and FIFO-limit cases.
module test_rd_capture_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  lat_sten = '0;
    logic [4:0]  lat_fifo = '0;
    logic        sdr_mode = 1'b0;
    logic [1:0]  fac_sel = '0;
    logic        strb_pulse = 1'b0;
    logic [3:0]  dq_pos = '0;
    logic [3:0]  dq_neg = '0;
    logic        pop = 1'b0;
    logic        sten_o, rfifo_en_o, word_vld, rd_empty, rd_full, ovf_flag, udf_flag;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    rd_capture_path i_rd_capture_path (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // advance to just after the next rising edge
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] smp(input int n);
        return 4'((n * 5 + 3) & 15);
    endfunction

    function automatic int fac_of(input int sel);
        return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
    endfunction

    // pop one word and compare it
    task automatic pop_check(input logic [31:0] exp, input string req);
        @(negedge clk);
        chk(!rd_empty && rd_data == exp, req, rd_data, exp);
        pop = 1'b1;
        cyc();
        pop = 1'b0;
    endtask

    // R5 R6 R7 R10: pack nw words and read them back
    task automatic run_deser(input bit sdr, input int sel, input int nw);
        int f, k, cpw, done_cnt;
        logic [31:0] exp;
        f = fac_of(sel);
        k = sdr ? 1 : 2;
        cpw = f / k;
        done_cnt = 0;
        sdr_mode = sdr;
        fac_sel = 2'(sel);
        lat_sten = '0;
        lat_fifo = '0;
        cyc();
        cyc();
        rd_en = 1'b1;
        cyc();
        for (int m = 0; m < nw * cpw; m++) begin
            strb_pulse = 1'b1;
            dq_pos = smp(m * k);
            dq_neg = sdr ? ~smp(m * k) : smp(m * k + 1);
            @(negedge clk);
            chk(word_vld == ((m + 1) % cpw == 0), sdr ? "R6 word_vld" : "R5 word_vld",
                32'(word_vld), 32'((m + 1) % cpw == 0));
            chk(rd_empty == (done_cnt == 0), "R7 zero-cycle write", 32'(rd_empty),
                32'(done_cnt == 0));
            if ((m + 1) % cpw == 0) done_cnt++;
            cyc();
        end
        strb_pulse = 1'b0;
        rd_en = 1'b0;
        cyc();
        cyc();
        for (int w = 0; w < nw; w++) begin
            exp = '0;
            for (int j = 0; j < f; j++) exp[j*4 +: 4] = smp(w * f + j);
            pop_check(exp, sdr ? "R6 SDR word / R10 order" : "R5 DDR word / R10 order");
        end
        @(negedge clk);
        chk(rd_empty, "R10 drained", 32'(rd_empty), 32'd1);
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int first_s, first_f, ns, nf;
        logic [31:0] exp;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!sten_o && !rfifo_en_o && !word_vld, "R13 enables low",
            {sten_o, rfifo_en_o, word_vld}, 0);
        chk(rd_empty && !rd_full && !ovf_flag && !udf_flag, "R13 FIFO state",
            {rd_empty, rd_full, ovf_flag, udf_flag}, 32'b1000);
        cyc();

        // R1 R2: every latency, the lines mirrored
        for (int l = 0; l < 32; l++) begin
            lat_sten = 5'(l);
            lat_fifo = 5'(31 - l);
            cyc();
            cyc();
            first_s = -1; first_f = -1; ns = 0; nf = 0;
            for (int c = 0; c < 36; c++) begin
                rd_en = (c == 0);
                @(negedge clk);
                if (sten_o) begin ns++; if (first_s < 0) first_s = c; end
                if (rfifo_en_o) begin nf++; if (first_f < 0) first_f = c; end
                cyc();
            end
            chk(first_s == l + 1 && ns == 1, "R1 strobe-enable delay", first_s, l + 1);
            chk(first_f == 32 - l && nf == 1, "R2 FIFO-enable delay", first_f, 32 - l);
        end

        // R3: change lat_sten mid-flight, also with a new rd_en in that cycle
        lat_sten = 5'd10;
        lat_fifo = 5'd10;
        cyc();
        cyc();
        first_f = -1; ns = 0; nf = 0;
        for (int c = 0; c < 40; c++) begin
            rd_en = (c == 0) || (c == 3);
            if (c == 3) lat_sten = 5'd12;
            @(negedge clk);
            if (sten_o) ns++;
            if (rfifo_en_o) begin nf++; if (first_f < 0) first_f = c; end
            cyc();
        end
        chk(ns == 0, "R3 flush drops in-flight pulses", ns, 0);
        chk(first_f == 11 && nf == 2, "R3 other line undisturbed", first_f, 11);
        first_s = -1;
        for (int c = 0; c < 16; c++) begin
            rd_en = (c == 0);
            @(negedge clk);
            if (sten_o && first_s < 0) first_s = c;
            cyc();
        end
        chk(first_s == 13, "R3 new latency after flush", first_s, 13);

        // R5 R6 R7 R10: all factor codes in both modes
        for (int s = 0; s < 2; s++)
            for (int sel = 0; sel < 4; sel++)
                run_deser(s[0], sel, 3);

        // R4: strobe with no enable
        lat_sten = '0; lat_fifo = '0; sdr_mode = 1'b0; fac_sel = 2'd0;
        cyc();
        cyc();
        ns = 0;
        for (int c = 0; c < 8; c++) begin
            strb_pulse = 1'b1; dq_pos = 4'(c); dq_neg = 4'(c + 1);
            @(negedge clk);
            if (word_vld) ns++;
            cyc();
        end
        strb_pulse = 1'b0;
        @(negedge clk);
        chk(ns == 0 && rd_empty, "R4 ungated strobe ignored", ns, 0);
        cyc();

        // R8: partial word then a fresh word, factor 8 DDR
        fac_sel = 2'd2;
        cyc();
        for (int c = 0; c < 10; c++) begin
            rd_en = (c == 0) || (c >= 3 && c <= 7);
            strb_pulse = (c == 1) || (c == 2) || (c >= 4 && c <= 7);
            if (c < 4) begin dq_pos = 4'hF; dq_neg = 4'hE; end
            else begin dq_pos = smp(2 * (c - 4) + 40); dq_neg = smp(2 * (c - 4) + 41); end
            @(negedge clk);
            chk(word_vld == (c == 7), (c == 2) ? "R4 gated off" : "R8 partial discarded",
                32'(word_vld), 32'(c == 7));
            cyc();
        end
        rd_en = 1'b0; strb_pulse = 1'b0;
        cyc();
        exp = '0;
        for (int j = 0; j < 8; j++) exp[j*4 +: 4] = smp(40 + j);
        pop_check(exp, "R8 fresh word from lane 0");

        // R9: word completes while FIFO enable is low
        fac_sel = 2'd0;
        lat_fifo = 5'd5;
        cyc();
        cyc();
        for (int c = 0; c < 10; c++) begin
            rd_en = (c == 0);
            strb_pulse = (c == 1);
            dq_pos = 4'h5; dq_neg = 4'hA;
            @(negedge clk);
            if (c == 1) chk(word_vld && !rfifo_en_o, "R9 word without enable",
                            {word_vld, rfifo_en_o}, 32'b10);
            cyc();
        end
        strb_pulse = 1'b0;
        @(negedge clk);
        chk(rd_empty, "R9 word not written", 32'(rd_empty), 32'd1);
        cyc();

        // R11: five words into a four-deep FIFO
        lat_fifo = '0;
        cyc();
        cyc();
        for (int c = 0; c < 7; c++) begin
            rd_en = (c <= 5);
            strb_pulse = (c >= 1 && c <= 5);
            dq_pos = 4'(c); dq_neg = ~4'(c);
            @(negedge clk);
            chk(ovf_flag == (c == 6), "R11 overflow pulse", 32'(ovf_flag), 32'(c == 6));
            if (c == 6) chk(rd_full, "R11 still full", 32'(rd_full), 32'd1);
            cyc();
        end
        rd_en = 1'b0; strb_pulse = 1'b0;
        cyc();
        for (int w = 1; w <= 4; w++)
            pop_check({24'd0, ~4'(w), 4'(w)}, "R11 contents intact");

        // R12: pop on empty
        @(negedge clk);
        chk(rd_empty && !udf_flag, "R12 empty before pop", {rd_empty, udf_flag}, 32'b10);
        pop = 1'b1;
        cyc();
        pop = 1'b0;
        @(negedge clk);
        chk(udf_flag && rd_empty, "R12 underflow pulse", {udf_flag, rd_empty}, 32'b11);
        cyc();
        @(negedge clk);
        chk(!udf_flag && !ovf_flag, "R12 pulse one cycle", {udf_flag, ovf_flag}, 0);

        finish_run();
    end

endmodule